// File: doc/BRIEF.md
# Power-on EEPROM auto-load sequencer

After power-on reset this block decides whether the chip loads its register banks from an external serial EEPROM or goes straight to slave operation. It clears every register word to zero and then opens an enable window that lasts a set number of millisecond ticks. If the enable input is high at any time inside that window, the block acts as bus master. It asks a separate two-wire byte engine for one word at a time and stores each returned word in a local register file that holds two banks.

One select pin picks which EEPROM word range feeds each bank. A second select pin tells the byte engine whether to send a one-byte or a two-byte word address. The block retries failed download attempts once per millisecond tick. A failure is a bus that is busy at the start of an attempt, or a refused read at any point. A hard time limit ensures the block always ends in slave mode. In slave mode, changes on the enable input do nothing. Only a general-call-reset strobe or a read-again strobe from the slave command decoder restarts the sequence.

Top module: `boot_autoload`

## Requirements
- R1: On reset, and on every restart from slave mode, all 2*BANK_WORDS register words read as zero, `load_done` and `load_fail` are 0, and `master_busy` is 1.
- R2: The block stays in the enable window until WIN_MS ticks have passed. If `en_in` is never high in that time, it enters slave mode with no read request, and both flags stay 0. If `en_in` rises at any point inside the window, the download starts.
- R3: A download requests the words in order, one request per word. The k-th returned word is stored at register index k (0 to 2*BANK_WORDS-1).
- R4: When `map_sel`=0, bank 0 (indices 0..BANK_WORDS-1) comes from EEPROM words B0_LO onward (default 0..23), and bank 1 comes from words B1_LO onward (default 24..47). When `map_sel`=1, the sources are B0_HI onward (default 361..384) and B1_HI onward (default 405..428).
- R5: When the last word has been acknowledged, the block enters slave mode (`master_busy`=0) with `load_done`=1 and `load_fail`=0.
- R6: In slave mode, `en_in` has no effect. Only a one-cycle `gcr_strobe` or `ra_strobe` restarts the enable window.
- R7: `map_sel` and `wide_sel` are captured when the download starts. Changing them during the download does not alter the addresses used.
- R8: While a request is active, `rd_wide` equals the captured `wide_sel` (1 means a two-byte word address).
- R9: An attempt fails when `bus_busy` is high on its first word, or when `rd_nack` arrives for any word. A failed attempt zeroes the banks. The next attempt starts on the next tick. After MAX_TRY failed attempts, the block enters slave mode with `load_fail`=1.
- R10: Slave mode is reached within TIMEOUT_MS ticks of reset or restart. If the time limit is hit, `load_fail`=1 and the banks read as zero.
- R11: `master_busy` is 1 in every state except slave mode. `rd_req` and the done/fail flags are never high while `master_busy` disagrees with them.
- R12: `rd_addr` stays constant while a request waits for its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| en_in | input | 1 | Auto-load enable |
| map_sel | input | 1 | EEPROM word range select |
| wide_sel | input | 1 | Two-byte word address select |
| gcr_strobe | input | 1 | General-call-reset pulse from slave decoder |
| ra_strobe | input | 1 | Read-again pulse from slave decoder |
| rd_req | output | 1 | Word read request to byte engine |
| rd_addr | output | AW | EEPROM word address of the request |
| rd_wide | output | 1 | Address width for the byte engine |
| rd_ack | input | 1 | Word returned, one-cycle pulse |
| rd_nack | input | 1 | Read refused, one-cycle pulse |
| bus_busy | input | 1 | Two-wire bus held by another master |
| rd_data | input | WORD_W | Returned word |
| reg_idx | input | IW | Register file read index |
| reg_val | output | WORD_W | Register file read data |
| master_busy | output | 1 | High until slave mode is entered |
| load_done | output | 1 | Download completed |
| load_fail | output | 1 | Download abandoned |

## Verification
The bench keeps every default parameter: 24-word banks, a 10-tick window, 10 attempts and a 25-tick limit. It compresses the millisecond tick to one pulse every 20 clocks. At that rate the full retry budget, the expiry of the time limit and the window closing all fit in a few hundred cycles each, so the exhaustion and timeout paths are tested at their real counts instead of at scaled-down ones. Both address maps are used, including the default high bases 361 and 405 and the jump between the two banks.

// File: rtl/boot_autoload.sv
`timescale 1ns/1ps
module boot_autoload #(
  parameter int WORD_W     = 8,
  parameter int BANK_WORDS = 24,
  parameter int AW         = 10,
  parameter int WIN_MS     = 10,
  parameter int MAX_TRY    = 10,
  parameter int TIMEOUT_MS = 25,
  parameter int B0_LO      = 0,
  parameter int B1_LO      = 24,
  parameter int B0_HI      = 361,
  parameter int B1_HI      = 405,
  parameter int IW         = $clog2(2*BANK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              en_in,
  input  logic              map_sel,
  input  logic              wide_sel,
  input  logic              gcr_strobe,
  input  logic              ra_strobe,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic              rd_wide,
  input  logic              rd_ack,
  input  logic              rd_nack,
  input  logic              bus_busy,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [IW-1:0]     reg_idx,
  output logic [WORD_W-1:0] reg_val,
  output logic              master_busy,
  output logic              load_done,
  output logic              load_fail
);
  localparam int NW  = 2*BANK_WORDS;
  localparam int MSW = $clog2(TIMEOUT_MS+1);
  localparam int TW  = $clog2(MAX_TRY+1);

  typedef enum logic [1:0] {S_WIN, S_REQ, S_RETRY, S_SLAVE} st_t;

  st_t               state;
  logic [IW-1:0]     widx;
  logic [MSW-1:0]    ms_cnt;
  logic [TW-1:0]     tries;
  logic              map_q, wide_q;
  logic [WORD_W-1:0] bank [NW];

  logic [AW-1:0] base0, base1;
  logic timeout, try_fail, reload, wipe, last;

  assign base0       = map_q ? AW'(B0_HI) : AW'(B0_LO);
  assign base1       = map_q ? AW'(B1_HI) : AW'(B1_LO);
  assign rd_addr     = (widx < IW'(BANK_WORDS)) ? base0 + AW'(widx)
                                                : base1 + AW'(widx - IW'(BANK_WORDS));
  assign rd_req      = (state == S_REQ);
  assign rd_wide     = wide_q;
  assign master_busy = (state != S_SLAVE);
  assign reg_val     = (reg_idx < IW'(NW)) ? bank[reg_idx] : '0;

  assign timeout  = master_busy && tick_ms && (ms_cnt == MSW'(TIMEOUT_MS-1));
  assign try_fail = rd_req && ((widx == '0 && bus_busy) || rd_nack);
  assign reload   = (state == S_SLAVE) && (gcr_strobe || ra_strobe);
  assign wipe     = reload || timeout || try_fail;
  assign last     = (widx == IW'(NW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_WIN;
      widx      <= '0;
      ms_cnt    <= '0;
      tries     <= '0;
      map_q     <= 1'b0;
      wide_q    <= 1'b0;
      load_done <= 1'b0;
      load_fail <= 1'b0;
      for (int i = 0; i < NW; i++) bank[i] <= '0;
    end else begin
      if (master_busy && tick_ms && !timeout) ms_cnt <= ms_cnt + 1'b1;
      if (timeout) begin
        state     <= S_SLAVE;
        load_fail <= 1'b1;
      end else begin
        case (state)
          S_WIN:
            if (en_in) begin
              state  <= S_REQ;
              map_q  <= map_sel;
              wide_q <= wide_sel;
              widx   <= '0;
            end else if (tick_ms && ms_cnt == MSW'(WIN_MS-1)) begin
              state <= S_SLAVE;
            end
          S_REQ:
            if (try_fail) begin
              widx  <= '0;
              tries <= tries + 1'b1;
              if (tries == TW'(MAX_TRY-1)) begin
                state     <= S_SLAVE;
                load_fail <= 1'b1;
              end else begin
                state <= S_RETRY;
              end
            end else if (rd_ack) begin
              bank[widx] <= rd_data;
              if (last) begin
                state     <= S_SLAVE;
                load_done <= 1'b1;
              end else begin
                widx <= widx + 1'b1;
              end
            end
          S_RETRY:
            if (tick_ms) state <= S_REQ;
          default:
            if (reload) begin
              state     <= S_WIN;
              ms_cnt    <= '0;
              tries     <= '0;
              widx      <= '0;
              load_done <= 1'b0;
              load_fail <= 1'b0;
            end
        endcase
      end
      if (wipe) for (int i = 0; i < NW; i++) bank[i] <= '0;
    end
  end

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && load_fail));
  assert_req_in_master_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> master_busy);
  assert_flag_in_slave_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done || load_fail) |-> !master_busy);
  assert_try_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TW'(MAX_TRY));
  assert_time_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt < MSW'(TIMEOUT_MS));
  assert_wide_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> $stable(rd_wide));
  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !rd_nack) |=> (!rd_req || $stable(rd_addr)));
endmodule

// File: tb/boot_autoload_bench.sv
`timescale 1ns/1ps
module boot_autoload_bench;
  localparam int TICK = 20;
  localparam int BW   = 24;
  localparam int NW   = 2*BW;

  logic clk = 0, rst_n = 0, tick_ms = 0, en_in = 0, map_sel = 0, wide_sel = 0;
  logic gcr_strobe = 0, ra_strobe = 0, rd_ack = 0, rd_nack = 0, bus_busy = 0;
  logic [7:0] rd_data = 0;
  logic [5:0] reg_idx = 0;
  logic rd_req, rd_wide, master_busy, load_done, load_fail;
  logic [9:0] rd_addr;
  logic [7:0] reg_val;

  int checks = 0, failures = 0;
  int rises = 0, first_addr = -1, wide_seen = 0;
  int nack_left = 0, nack_addr = -1;
  bit mute = 0, req_prev = 0;

  boot_autoload u_boot_autoload (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .en_in(en_in), .map_sel(map_sel),
    .wide_sel(wide_sel), .gcr_strobe(gcr_strobe), .ra_strobe(ra_strobe),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_ack(rd_ack),
    .rd_nack(rd_nack), .bus_busy(bus_busy), .rd_data(rd_data), .reg_idx(reg_idx),
    .reg_val(reg_val), .master_busy(master_busy), .load_done(load_done),
    .load_fail(load_fail));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_val(int a);
    return 8'((a*37 + 11) ^ (a >> 2));
  endfunction

  function automatic int exp_addr(int k, bit m);
    if (k < BW) return (m ? 361 : 0) + k;
    return (m ? 405 : 24) + k - BW;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_regs(string tag, bit zero, bit m);
    int bad = 0, fa = 0, fe = 0;
    for (int k = 0; k < NW; k++) begin
      int e;
      reg_idx = 6'(k);
      #0.1;
      e = zero ? 0 : int'(mem_val(exp_addr(k, m)));
      if (int'(reg_val) != e && bad == 0) begin fa = reg_val; fe = e; end
      if (int'(reg_val) != e) bad++;
    end
    check(tag, fa, fe);
  endtask

  task automatic wait_slave(output int cyc);
    cyc = 0;
    while (master_busy && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic restart(bit use_gcr);
    @(negedge clk);
    rises = 0; first_addr = -1; wide_seen = 0;
    if (use_gcr) gcr_strobe = 1; else ra_strobe = 1;
    @(negedge clk);
    gcr_strobe = 0; ra_strobe = 0;
  endtask

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      tick_ms = (c % TICK == 0);
    end
  end

  initial forever begin
    @(negedge clk);
    if (rd_ack || rd_nack) begin
      rd_ack = 0; rd_nack = 0;
    end else if (rd_req && !mute && !bus_busy) begin
      if (nack_left > 0 && int'(rd_addr) == nack_addr) begin
        rd_nack = 1; nack_left--;
      end else begin
        rd_ack = 1; rd_data = mem_val(int'(rd_addr));
      end
    end
    if (rd_req && !req_prev) begin
      rises++; first_addr = int'(rd_addr); wide_seen = rd_wide;
    end
    req_prev = rd_req;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(4321));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", master_busy, 1);
    check("R1 done after reset", load_done, 0);
    check("R1 fail after reset", load_fail, 0);
    check_regs("R1 regs zero after reset", 1, 0);

    repeat (150) @(negedge clk);
    check("R2 window still open", master_busy, 1);
    wait_slave(cyc);
    check("R2 window closes in time", int'(cyc < 10*TICK), 1);
    check("R2 no request without enable", rises, 0);
    check("R2 flags stay clear", int'(load_done | load_fail), 0);

    en_in = 1;
    repeat (50) @(negedge clk);
    en_in = 0;
    check("R6 enable ignored in slave", master_busy, 0);
    check("R6 no request on enable", rises, 0);
    check_regs("R6 regs untouched", 1, 0);

    restart(0);
    check_regs("R1 regs zero on restart", 1, 0);
    repeat (5*TICK) @(negedge clk);
    check("R2 window open before late enable", master_busy, 1);
    en_in = 1;
    wait_slave(cyc);
    check("R5 done after late enable", load_done, 1);
    check("R4 first address low map", first_addr, 0);
    check("R8 narrow address", wide_seen, 0);
    check_regs("R3 R4 banks from low map", 0, 0);

    map_sel = 1; wide_sel = 1;
    restart(1);
    repeat (20) @(negedge clk);
    map_sel = 0; wide_sel = 0;
    wait_slave(cyc);
    check("R5 done high map", load_done, 1);
    check("R4 first address high map", first_addr, 361);
    check("R8 wide address", wide_seen, 1);
    check_regs("R7 R4 banks from latched high map", 0, 1);

    nack_addr = 5; nack_left = 2;
    restart(0);
    wait_slave(cyc);
    check("R9 success after two failures", load_done, 1);
    check("R9 three attempts", rises, 3);
    check_regs("R9 banks after retry", 0, 0);

    nack_addr = 5; nack_left = 100;
    restart(0);
    wait_slave(cyc);
    check("R9 fail flag after exhaustion", load_fail, 1);
    check("R9 done clear after exhaustion", load_done, 0);
    check("R9 attempt count limit", rises, 10);
    check("R10 exhaustion in time", int'(cyc <= 25*TICK + 2), 1);
    check_regs("R9 banks zero after mid failure", 1, 0);
    nack_left = 0;

    bus_busy = 1;
    restart(1);
    wait_slave(cyc);
    check("R9 busy bus exhausts", load_fail, 1);
    check("R9 busy attempt count", rises, 10);
    bus_busy = 0;

    mute = 1;
    restart(0);
    wait_slave(cyc);
    check("R10 timeout fail flag", load_fail, 1);
    check("R10 timeout bound", int'(cyc <= 25*TICK + 2), 1);
    check("R10 timeout not early", int'(cyc >= 24*TICK), 1);
    check("R12 single held request", rises, 1);
    check_regs("R10 banks zero after timeout", 1, 0);
    mute = 0;

    for (int it = 0; it < 6; it++) begin
      bit m;
      int n;
      m = 1'($urandom);
      map_sel = m;
      wide_sel = 1'($urandom);
      n = int'($urandom % 4);
      nack_left = n;
      nack_addr = exp_addr(int'($urandom % NW), m);
      restart(1'($urandom));
      wait_slave(cyc);
      check("R5 random done", load_done, 1);
      check("R9 random attempts", rises, n + 1);
      check("R8 random width", wide_seen, int'(wide_sel));
      check_regs("R3 R4 random banks", 0, m);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule